// File: doc/BRIEF.md
# Branch and Next-PC Unit

This block resolves control flow for a 32-bit load-store processor with fixed 32-bit instruction words. Each cycle it receives the current program counter, the instruction word and the two source operand values already read from the register file. From these it works out whether a control transfer happens, where execution continues, and whether a return address must be written back. All results are registered, so the outputs one clock after an input set belong to that set.

The block handles three kinds of transfer. The first is conditional branches, which either compare two operands for equality or test the sign of one operand. The second is jumps whose target lies in the current 256 MB region. The third is jumps whose target comes from a register. Several of these forms also save a return address. When no transfer applies, including for any instruction the block does not recognise, execution continues at PC+4. Delay slots are not modelled, so every saved return address is PC+4.

Top module: `bnpc_unit`

## Requirements
- R1: While `rst_n` is low, every output is zero.
- R2: Outputs appear one clock after the inputs they depend on. An instruction that is not a recognised transfer gives next PC = PC+4, taken = 0 and link write = 0. Examples are an opcode 000000 word with a funct other than 001000 or 001001, opcode 001000, and opcode 100011.
- R3: The opcode sits in bits 31:26, rs in 25:21, rt in 20:16 and the 16-bit offset in 15:0. Opcode 000100 is taken when the rs and rt values are equal. Opcode 000101 is taken when they differ. A taken branch goes to PC+4 + sign-extended offset × 4.
- R4: Opcode 000110 is taken when the rs value, read as signed, is ≤ 0. Opcode 000111 is taken when it is > 0. Both use the target of R3.
- R5: Under opcode 000001 the rt field selects the test. 00000 means rs < 0. 00001 means rs ≥ 0. 10000 means rs < 0 with link. 10001 means rs ≥ 0 with link. Any other rt value is not a transfer.
- R6: Opcode 000010 always jumps to {PC+4[31:28], instr[25:0], 2'b00}. Opcode 000011 does the same and links into register 31.
- R7: In an opcode 000000 word, funct (bits 5:0) 001000 jumps to the rs value with no link. Funct 001001 jumps to the rs value and links into the register named by bits 15:11.
- R8: A link write happens only when the transfer is taken. Its value is PC+4. When no link write happens, the link register number and link value outputs are 0.
- R9: Target arithmetic wraps modulo 2^32 in both directions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pc_i | input | 32 | Address of the current instruction |
| instr_i | input | 32 | Current instruction word |
| rs_val_i | input | 32 | Value of the register named by rs |
| rt_val_i | input | 32 | Value of the register named by rt |
| next_pc_o | output | 32 | Address to fetch next |
| taken_o | output | 1 | A control transfer occurred |
| link_we_o | output | 1 | Write the return address |
| link_rd_o | output | 5 | Register receiving the return address |
| link_val_o | output | 32 | Return address value |

## Verification
A wrong decode class or condition shows up one cycle later at `next_pc_o` and `taken_o`: a branch falls through when it should go, or goes when it should fall through. A wrong link flag appears in that same cycle as `link_we_o` set on a branch that was not taken, or a wrong register number. Because the block keeps no state beyond its output register, each fault is confined to the single result it corrupts. Directed cases therefore place every condition on both sides of its threshold: zero, one, minus one and the most negative value. They also cover region and wrap-around boundaries.

// File: rtl/bnpc_pkg.sv
package bnpc_pkg;

    parameter int XLEN    = 32;
    parameter int REG_AW  = 5;
    parameter int OP_W    = 6;
    parameter int IMM_W   = 16;
    parameter int IDX_W   = 26;

    localparam logic [OP_W-1:0] OP_SPECIAL = 6'b000000;
    localparam logic [OP_W-1:0] OP_REGIMM  = 6'b000001;
    localparam logic [OP_W-1:0] OP_J       = 6'b000010;
    localparam logic [OP_W-1:0] OP_JAL     = 6'b000011;
    localparam logic [OP_W-1:0] OP_BEQ     = 6'b000100;
    localparam logic [OP_W-1:0] OP_BNE     = 6'b000101;
    localparam logic [OP_W-1:0] OP_BLEZ    = 6'b000110;
    localparam logic [OP_W-1:0] OP_BGTZ    = 6'b000111;

    localparam logic [5:0] FN_JR   = 6'b001000;
    localparam logic [5:0] FN_JALR = 6'b001001;

    localparam logic [REG_AW-1:0] RT_LTZ   = 5'b00000;
    localparam logic [REG_AW-1:0] RT_GEZ   = 5'b00001;
    localparam logic [REG_AW-1:0] RT_LTZAL = 5'b10000;
    localparam logic [REG_AW-1:0] RT_GEZAL = 5'b10001;

    localparam logic [REG_AW-1:0] RA_REG = 5'd31;

    typedef enum logic [2:0] {
        CK_NEVER,
        CK_EQ,
        CK_NE,
        CK_LEZ,
        CK_GTZ,
        CK_LTZ,
        CK_GEZ,
        CK_ALWAYS
    } cond_e;

    typedef enum logic [1:0] {
        TS_SEQ,
        TS_REL,
        TS_REGION,
        TS_REG
    } tsel_e;

    typedef struct packed {
        cond_e             cond;
        tsel_e             tsel;
        logic              link;
        logic [REG_AW-1:0] link_rd;
    } ctl_t;

    typedef struct packed {
        logic [XLEN-1:0]   next_pc;
        logic              taken;
        logic              link_we;
        logic [REG_AW-1:0] link_rd;
        logic [XLEN-1:0]   link_val;
    } npc_out_t;

endpackage

// File: rtl/bnpc_decode.sv
module bnpc_decode
    import bnpc_pkg::*;
(
    input  logic [OP_W-1:0]   opcode_i,
    input  logic [REG_AW-1:0] rt_f_i,
    input  logic [REG_AW-1:0] rd_f_i,
    input  logic [5:0]        funct_i,
    output ctl_t              ctl_o
);

    always_comb begin
        ctl_o.cond    = CK_NEVER;
        ctl_o.tsel    = TS_SEQ;
        ctl_o.link    = 1'b0;
        ctl_o.link_rd = '0;
        unique case (opcode_i)
            OP_SPECIAL: begin
                if (funct_i == FN_JR) begin
                    ctl_o.cond = CK_ALWAYS;
                    ctl_o.tsel = TS_REG;
                end else if (funct_i == FN_JALR) begin
                    ctl_o.cond    = CK_ALWAYS;
                    ctl_o.tsel    = TS_REG;
                    ctl_o.link    = 1'b1;
                    ctl_o.link_rd = rd_f_i;
                end
            end
            OP_REGIMM: begin
                ctl_o.tsel = TS_REL;
                unique case (rt_f_i)
                    RT_LTZ:   ctl_o.cond = CK_LTZ;
                    RT_GEZ:   ctl_o.cond = CK_GEZ;
                    RT_LTZAL: begin
                        ctl_o.cond    = CK_LTZ;
                        ctl_o.link    = 1'b1;
                        ctl_o.link_rd = RA_REG;
                    end
                    RT_GEZAL: begin
                        ctl_o.cond    = CK_GEZ;
                        ctl_o.link    = 1'b1;
                        ctl_o.link_rd = RA_REG;
                    end
                    default: begin
                        ctl_o.cond = CK_NEVER;
                        ctl_o.tsel = TS_SEQ;
                    end
                endcase
            end
            OP_J: begin
                ctl_o.cond = CK_ALWAYS;
                ctl_o.tsel = TS_REGION;
            end
            OP_JAL: begin
                ctl_o.cond    = CK_ALWAYS;
                ctl_o.tsel    = TS_REGION;
                ctl_o.link    = 1'b1;
                ctl_o.link_rd = RA_REG;
            end
            OP_BEQ: begin
                ctl_o.cond = CK_EQ;
                ctl_o.tsel = TS_REL;
            end
            OP_BNE: begin
                ctl_o.cond = CK_NE;
                ctl_o.tsel = TS_REL;
            end
            OP_BLEZ: begin
                ctl_o.cond = CK_LEZ;
                ctl_o.tsel = TS_REL;
            end
            OP_BGTZ: begin
                ctl_o.cond = CK_GTZ;
                ctl_o.tsel = TS_REL;
            end
            default: ;
        endcase
    end

    // R7: a register-target selection only ever comes from the zero opcode group
    always_comb begin
        if (ctl_o.tsel == TS_REG)
            p_regjump_special_r7: assert (opcode_i == OP_SPECIAL);
    end

endmodule

// File: rtl/bnpc_cond.sv
module bnpc_cond
    import bnpc_pkg::*;
#(
    parameter int W = XLEN
) (
    input  cond_e        cond_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic         hit_o
);

    logic is_neg;
    logic is_zero;
    logic is_same;

    assign is_neg  = a_i[W-1];
    assign is_zero = (a_i == '0);
    assign is_same = (a_i == b_i);

    always_comb begin
        unique case (cond_i)
            CK_NEVER:  hit_o = 1'b0;
            CK_EQ:     hit_o = is_same;
            CK_NE:     hit_o = !is_same;
            CK_LEZ:    hit_o = is_neg || is_zero;
            CK_GTZ:    hit_o = !is_neg && !is_zero;
            CK_LTZ:    hit_o = is_neg;
            CK_GEZ:    hit_o = !is_neg;
            CK_ALWAYS: hit_o = 1'b1;
            default:   hit_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/bnpc_target.sv
module bnpc_target
    import bnpc_pkg::*;
#(
    parameter int W = XLEN
) (
    input  tsel_e            tsel_i,
    input  logic [W-1:0]     pc_i,
    input  logic [IMM_W-1:0] imm_i,
    input  logic [IDX_W-1:0] idx_i,
    input  logic [W-1:0]     reg_i,
    output logic [W-1:0]     pc4_o,
    output logic [W-1:0]     target_o
);

    localparam int SEXT_W   = W - IMM_W - 2;
    localparam int REGION_W = W - IDX_W - 2;

    logic [W-1:0] rel_off;
    logic [W-1:0] rel_tgt;
    logic [W-1:0] region_tgt;

    assign pc4_o      = pc_i + W'(4);
    assign rel_off    = {{SEXT_W{imm_i[IMM_W-1]}}, imm_i, 2'b00};
    assign rel_tgt    = pc4_o + rel_off;
    assign region_tgt = {pc4_o[W-1 -: REGION_W], idx_i, 2'b00};

    always_comb begin
        unique case (tsel_i)
            TS_REL:    target_o = rel_tgt;
            TS_REGION: target_o = region_tgt;
            TS_REG:    target_o = reg_i;
            default:   target_o = pc4_o;
        endcase
    end

endmodule

// File: rtl/bnpc_unit.sv
module bnpc_unit
    import bnpc_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [XLEN-1:0]       pc_i,
    input  logic [XLEN-1:0]       instr_i,
    input  logic [XLEN-1:0]       rs_val_i,
    input  logic [XLEN-1:0]       rt_val_i,
    output logic [XLEN-1:0]       next_pc_o,
    output logic                  taken_o,
    output logic                  link_we_o,
    output logic [REG_AW-1:0]     link_rd_o,
    output logic [XLEN-1:0]       link_val_o
);

    ctl_t            ctl;
    logic            hit;
    logic [XLEN-1:0] pc4;
    logic [XLEN-1:0] target;
    npc_out_t        out_d;
    npc_out_t        out_q;

    bnpc_decode u_dec (
        .opcode_i (instr_i[31:26]),
        .rt_f_i   (instr_i[20:16]),
        .rd_f_i   (instr_i[15:11]),
        .funct_i  (instr_i[5:0]),
        .ctl_o    (ctl)
    );

    bnpc_cond #(.W(XLEN)) u_cond (
        .cond_i (ctl.cond),
        .a_i    (rs_val_i),
        .b_i    (rt_val_i),
        .hit_o  (hit)
    );

    bnpc_target #(.W(XLEN)) u_tgt (
        .tsel_i   (ctl.tsel),
        .pc_i     (pc_i),
        .imm_i    (instr_i[IMM_W-1:0]),
        .idx_i    (instr_i[IDX_W-1:0]),
        .reg_i    (rs_val_i),
        .pc4_o    (pc4),
        .target_o (target)
    );

    always_comb begin
        out_d.taken    = hit;
        out_d.next_pc  = hit ? target : pc4;
        out_d.link_we  = hit && ctl.link;
        out_d.link_rd  = out_d.link_we ? ctl.link_rd : '0;
        out_d.link_val = out_d.link_we ? pc4 : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign next_pc_o  = out_q.next_pc;
    assign taken_o    = out_q.taken;
    assign link_we_o  = out_q.link_we;
    assign link_rd_o  = out_q.link_rd;
    assign link_val_o = out_q.link_val;

    // Marks that at least one input set has been registered since reset.
    logic live_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) live_q <= 1'b0;
        else        live_q <= 1'b1;
    end

    p_fallthru_r2: assert property (@(posedge clk) disable iff (!rst_n || !live_q)
        !taken_o |-> (next_pc_o == $past(pc_i) + XLEN'(4)) && !link_we_o);

    p_link_taken_r8: assert property (@(posedge clk) disable iff (!rst_n || !live_q)
        link_we_o |-> taken_o);

    p_link_value_r8: assert property (@(posedge clk) disable iff (!rst_n || !live_q)
        link_we_o |-> link_val_o == $past(pc_i) + XLEN'(4));

    p_idle_link_r8: assert property (@(posedge clk) disable iff (!rst_n || !live_q)
        !link_we_o |-> link_rd_o == '0 && link_val_o == '0);

    p_region_jump_r6: assert property (@(posedge clk) disable iff (!rst_n || !live_q)
        ($past(instr_i[31:26]) == OP_J) |->
            taken_o && next_pc_o[1:0] == 2'b00 && next_pc_o[27:2] == $past(instr_i[25:0]));

    p_jal_ra_r6: assert property (@(posedge clk) disable iff (!rst_n || !live_q)
        ($past(instr_i[31:26]) == OP_JAL) |-> link_we_o && link_rd_o == RA_REG);

endmodule

// File: tb/sim_bnpc_unit.sv
module sim_bnpc_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pc_i = '0;
    logic [31:0] instr_i = '0;
    logic [31:0] rs_val_i = '0;
    logic [31:0] rt_val_i = '0;
    logic [31:0] next_pc_o;
    logic        taken_o;
    logic        link_we_o;
    logic [4:0]  link_rd_o;
    logic [31:0] link_val_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    bnpc_unit u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .pc_i       (pc_i),
        .instr_i    (instr_i),
        .rs_val_i   (rs_val_i),
        .rt_val_i   (rt_val_i),
        .next_pc_o  (next_pc_o),
        .taken_o    (taken_o),
        .link_we_o  (link_we_o),
        .link_rd_o  (link_rd_o),
        .link_val_o (link_val_o)
    );

    function automatic logic [31:0] enc_i(input logic [5:0] op, input logic [4:0] rs,
                                          input logic [4:0] rt, input logic [15:0] imm);
        return {op, rs, rt, imm};
    endfunction

    function automatic logic [31:0] enc_j(input logic [5:0] op, input logic [25:0] idx);
        return {op, idx};
    endfunction

    function automatic logic [31:0] enc_r(input logic [4:0] rs, input logic [4:0] rd,
                                          input logic [5:0] fn);
        return {6'b000000, rs, 5'd0, rd, 5'd0, fn};
    endfunction

    task automatic expect_out(input logic [31:0] e_npc, input logic e_tk, input logic e_we,
                              input logic [4:0] e_rd, input logic [31:0] e_val, input string tag);
        n_chk++;
        if (next_pc_o !== e_npc || taken_o !== e_tk || link_we_o !== e_we ||
            link_rd_o !== e_rd || link_val_o !== e_val) begin
            n_bad++;
            $display("FAIL %s: got npc=%h tk=%b we=%b rd=%0d val=%h, expected npc=%h tk=%b we=%b rd=%0d val=%h",
                     tag, next_pc_o, taken_o, link_we_o, link_rd_o, link_val_o,
                     e_npc, e_tk, e_we, e_rd, e_val);
        end
    endtask

    task automatic run(input logic [31:0] pc, input logic [31:0] ins, input logic [31:0] rs,
                       input logic [31:0] rt, input logic [31:0] e_npc, input logic e_tk,
                       input logic e_we, input logic [4:0] e_rd, input logic [31:0] e_val,
                       input string tag);
        @(negedge clk);
        pc_i = pc; instr_i = ins; rs_val_i = rs; rt_val_i = rt;
        @(posedge clk);
        #1;
        expect_out(e_npc, e_tk, e_we, e_rd, e_val, tag);
    endtask

    task automatic t_reset;
        pc_i = 32'h0000_0100; instr_i = enc_j(6'b000011, 26'h3);
        repeat (3) @(posedge clk);
        #1;
        expect_out('0, 1'b0, 1'b0, 5'd0, '0, "R1 outputs zero in reset");
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_fallthru;
        run(32'h40, enc_r(5'd1, 5'd2, 6'b100000), 32'h5, 32'h5, 32'h44, 0, 0, 0, 0, "R2 R-type non-jump");
        run(32'h40, enc_i(6'b001000, 5'd1, 5'd2, 16'h0010), 32'h0, 32'h0, 32'h44, 0, 0, 0, 0, "R2 opcode 001000");
        run(32'h40, enc_i(6'b100011, 5'd1, 5'd2, 16'hFFFF), 32'h0, 32'h0, 32'h44, 0, 0, 0, 0, "R2 opcode 100011");
    endtask

    task automatic t_equality;
        run(32'h100, enc_i(6'b000100, 5'd1, 5'd2, 16'd4), 32'd7, 32'd7, 32'h114, 1, 0, 0, 0, "R3 beq equal");
        run(32'h100, enc_i(6'b000100, 5'd1, 5'd2, 16'd4), 32'd7, 32'd8, 32'h104, 0, 0, 0, 0, "R3 beq differ");
        run(32'h200, enc_i(6'b000101, 5'd1, 5'd2, 16'hFFFE), 32'd9, 32'd9, 32'h204, 0, 0, 0, 0, "R3 bne equal");
        run(32'h200, enc_i(6'b000101, 5'd1, 5'd2, 16'hFFFE), 32'd9, 32'd10, 32'h1FC, 1, 0, 0, 0, "R3 bne differ backward");
    endtask

    task automatic t_sign;
        run(32'h300, enc_i(6'b000110, 5'd3, 5'd0, 16'h10), 32'h0, 32'h0, 32'h344, 1, 0, 0, 0, "R4 blez zero");
        run(32'h300, enc_i(6'b000110, 5'd3, 5'd0, 16'h10), 32'h1, 32'h0, 32'h304, 0, 0, 0, 0, "R4 blez one");
        run(32'h300, enc_i(6'b000110, 5'd3, 5'd0, 16'h10), 32'h8000_0000, 32'h0, 32'h344, 1, 0, 0, 0, "R4 blez most negative");
        run(32'h300, enc_i(6'b000111, 5'd3, 5'd0, 16'h10), 32'h1, 32'h0, 32'h344, 1, 0, 0, 0, "R4 bgtz one");
        run(32'h300, enc_i(6'b000111, 5'd3, 5'd0, 16'h10), 32'h0, 32'h0, 32'h304, 0, 0, 0, 0, "R4 bgtz zero");
        run(32'h300, enc_i(6'b000111, 5'd3, 5'd0, 16'h10), 32'hFFFF_FFFF, 32'h0, 32'h304, 0, 0, 0, 0, "R4 bgtz minus one");
    endtask

    task automatic t_regimm;
        run(32'h1000, enc_i(6'b000001, 5'd4, 5'b00000, 16'h8), 32'hFFFF_FFFF, 32'h0, 32'h1024, 1, 0, 0, 0, "R5 bltz negative");
        run(32'h1000, enc_i(6'b000001, 5'd4, 5'b00000, 16'h8), 32'h0, 32'h0, 32'h1004, 0, 0, 0, 0, "R5 bltz zero");
        run(32'h1000, enc_i(6'b000001, 5'd4, 5'b00001, 16'h8), 32'h0, 32'h0, 32'h1024, 1, 0, 0, 0, "R5 bgez zero");
        run(32'h1000, enc_i(6'b000001, 5'd4, 5'b00001, 16'h8), 32'h8000_0000, 32'h0, 32'h1004, 0, 0, 0, 0, "R5 bgez most negative");
        run(32'h1000, enc_i(6'b000001, 5'd4, 5'b10000, 16'h8), 32'hFFFF_FFFB, 32'h0, 32'h1024, 1, 1, 31, 32'h1004, "R5 R8 bltzal taken links");
        run(32'h1000, enc_i(6'b000001, 5'd4, 5'b10000, 16'h8), 32'h3, 32'h0, 32'h1004, 0, 0, 0, 0, "R8 bltzal not taken no link");
        run(32'h1000, enc_i(6'b000001, 5'd4, 5'b10001, 16'h8), 32'h5, 32'h0, 32'h1024, 1, 1, 31, 32'h1004, "R5 R8 bgezal taken links");
        run(32'h1000, enc_i(6'b000001, 5'd4, 5'b10001, 16'h8), 32'hFFFF_FFFF, 32'h0, 32'h1004, 0, 0, 0, 0, "R8 bgezal not taken no link");
        run(32'h1000, enc_i(6'b000001, 5'd4, 5'b00010, 16'h8), 32'hFFFF_FFFF, 32'h0, 32'h1004, 0, 0, 0, 0, "R5 unknown rt 00010");
        run(32'h1000, enc_i(6'b000001, 5'd4, 5'b10010, 16'h8), 32'h0, 32'h0, 32'h1004, 0, 0, 0, 0, "R5 unknown rt 10010");
    endtask

    task automatic t_region;
        run(32'h4000_0010, enc_j(6'b000010, 26'd32), 32'h0, 32'h0, 32'h4000_0080, 1, 0, 0, 0, "R6 j region");
        run(32'h4000_0010, enc_j(6'b000011, 26'd32), 32'h0, 32'h0, 32'h4000_0080, 1, 1, 31, 32'h4000_0014, "R6 jal links ra");
        run(32'h0FFF_FFFC, enc_j(6'b000010, 26'd0), 32'h0, 32'h0, 32'h1000_0000, 1, 0, 0, 0, "R6 region from pc+4");
    endtask

    task automatic t_regjump;
        run(32'h500, enc_r(5'd6, 5'd0, 6'b001000), 32'h1234, 32'h0, 32'h1234, 1, 0, 0, 0, "R7 jr");
        run(32'h500, enc_r(5'd6, 5'd31, 6'b001001), 32'h8000, 32'h0, 32'h8000, 1, 1, 31, 32'h504, "R7 jalr rd 31");
        run(32'h500, enc_r(5'd6, 5'd5, 6'b001001), 32'h8000, 32'h0, 32'h8000, 1, 1, 5, 32'h504, "R7 jalr rd 5");
        run(32'h500, enc_r(5'd6, 5'd5, 6'b001010), 32'h8000, 32'h0, 32'h504, 0, 0, 0, 0, "R7 funct 001010 not a jump");
    endtask

    task automatic t_wrap;
        run(32'hFFFF_FFF8, enc_i(6'b000100, 5'd1, 5'd1, 16'd4), 32'h1, 32'h1, 32'h0000_000C, 1, 0, 0, 0, "R9 forward wrap");
        run(32'h0000_0000, enc_i(6'b000100, 5'd1, 5'd1, 16'hFFFE), 32'h1, 32'h1, 32'hFFFF_FFFC, 1, 0, 0, 0, "R9 backward wrap");
    endtask

    initial begin
        #800000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL R2 watchdog expired before the bench finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        t_reset;
        t_fallthru;
        t_equality;
        t_sign;
        t_regimm;
        t_region;
        t_regjump;
        t_wrap;
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule